// File: doc/BRIEF.md
# Constant-Engine Packet Sequencer with Draw-Engine Counter Sync

The block parses a stream of 32-bit command words. Each packet is one header word followed by a body. The block keeps a local constant RAM that packets can fill from their payload. Other packets copy a region of that RAM out through a memory write-request port. Two more packet kinds manage a pair of progress counters: one raises the constant-engine counter, and the other makes the parser wait until the draw engine is close enough behind.

The draw engine is modelled only by an increment strobe, which the block mirrors into its own draw counter. The block also drives a go flag. The draw side uses this flag to pass its own wait-on-constants point: the flag is high while the constant counter is ahead of the draw counter. A submission-start pulse clears both counters, any error and any packet in progress.

Header layout, counted from bit 0:
- Bits [31:30] hold the type.
- Bits [29:16] hold the count. The body is count+1 words long.
- Bits [15:8] hold the opcode.
- Bits [7:0] are ignored.

The RAM holds 2^CRAM_AW 32-bit words. A 48 KiB store needs CRAM_AW = 14 with the top quarter unused. The default is small.

Top module: `ce_sync_seq`

## Requirements
- R1: After reset: pkt_ready_o=1, both counters 0, err_o=0, wait_o=0, mem_wr_valid_o=0.
- R2: A header whose bits [31:30] are not 2'b11 sets err_o. From then on pkt_ready_o stays 0 until sub_start_i.
- R3: A header with an opcode outside {0x10, 0x81, 0x83, 0x84, 0x88} sets err_o and halts parsing in the same way as R2.
- R4: The body length is header bits [29:16] plus one. The word after the body is parsed as the next header, whatever the body's content.
- R5: Opcode 0x10 (no-op) is consumed with its body. It writes no RAM, issues no memory request and changes no counter.
- R6: Opcode 0x81 (write constants) takes body word 0 as a word offset. Each later body word k (k≥1) is stored at RAM word (offset+k-1) modulo the RAM depth.
- R7: Opcode 0x83 (dump constants) takes body word 0 as the RAM word offset, word 1 as the length in words and word 2 as the destination address. For i = 0 to length-1 it issues one request each: address destination+i, data RAM[(offset+i) mod depth]. A request holds its address and data while mem_wr_ready_i is 0. A length of 0 issues nothing.
- R8: Opcode 0x84 adds one to ce_cnt_o when its header is accepted. ce_cnt_o changes in no other way except by clearing.
- R9: Each cycle with de_inc_i high adds one to de_cnt_o.
- R10: Opcode 0x88 reads a threshold from body word 0. Parsing then stalls, with wait_o=1 and pkt_ready_o=0, while (de_cnt_o − ce_cnt_o) mod 2^32 ≥ threshold.
- R11: de_go_o is 1 exactly when ce_cnt_o > de_cnt_o as unsigned values.
- R12: sub_start_i clears both counters, err_o, wait_o and any packet in progress on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_start_i | input | 1 | Submission start, synchronous clear |
| pkt_valid_i | input | 1 | Command word valid |
| pkt_data_i | input | 32 | Command word |
| pkt_ready_o | output | 1 | Command word accepted when high with valid |
| de_inc_i | input | 1 | Draw-engine counter increment strobe |
| mem_wr_valid_o | output | 1 | Memory write request valid |
| mem_wr_ready_i | input | 1 | Memory write request accepted |
| mem_wr_addr_o | output | MAW | Memory write word address |
| mem_wr_data_o | output | 32 | Memory write data |
| ce_cnt_o | output | CW | Constant-engine counter |
| de_cnt_o | output | CW | Mirrored draw-engine counter |
| de_go_o | output | 1 | Draw side may pass its wait-on-constants point |
| wait_o | output | 1 | Parser stalled on counter distance |
| err_o | output | 1 | Parsing halted on a bad header |

## Verification
The hardest case to reach is a stall that ends without a clear. The distance only grows as draw increments arrive, so an ordinary stall never releases. The stimulus therefore first puts the constant counter ahead of the draw counter, which makes the wrapped distance huge. It then sets the threshold exactly equal to that distance. One draw increment must leave the parser stalled, and the second must release it. A dump that wraps the RAM index, served under alternating backpressure, covers the copy path's corner cases.

// File: rtl/ce_sync_pkg.sv
package ce_sync_pkg;

  localparam logic [1:0] HDR_TYPE = 2'b11;

  localparam logic [7:0] OPC_NOP  = 8'h10;
  localparam logic [7:0] OPC_WRC  = 8'h81;
  localparam logic [7:0] OPC_DUMP = 8'h83;
  localparam logic [7:0] OPC_INC  = 8'h84;
  localparam logic [7:0] OPC_WAIT = 8'h88;

  typedef enum logic [2:0] {
    ST_HDR, ST_BODY, ST_WAIT, ST_DUMP, ST_ERR
  } seq_st_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WRC, OP_DUMP, OP_INC, OP_WAIT
  } op_kind_e;

  typedef struct packed {
    logic        type_ok;
    logic        op_ok;
    op_kind_e    kind;
    logic [13:0] cnt;
  } hdr_t;

endpackage

// File: rtl/ce_sync_hdr_dec.sv
module ce_sync_hdr_dec
  import ce_sync_pkg::*;
(
  input  logic [31:8] word_i,
  output hdr_t        hdr_o
);

  always_comb begin
    hdr_o.type_ok = (word_i[31:30] == HDR_TYPE);
    hdr_o.cnt     = word_i[29:16];
    hdr_o.op_ok   = 1'b1;
    hdr_o.kind    = OP_NONE;
    unique case (word_i[15:8])
      OPC_NOP:  hdr_o.kind = OP_NONE;
      OPC_WRC:  hdr_o.kind = OP_WRC;
      OPC_DUMP: hdr_o.kind = OP_DUMP;
      OPC_INC:  hdr_o.kind = OP_INC;
      OPC_WAIT: hdr_o.kind = OP_WAIT;
      default:  hdr_o.op_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/ce_sync_cram.sv
module ce_sync_cram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/ce_sync_ctr.sv
module ce_sync_ctr #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ce_inc_i,
  input  logic          de_inc_i,
  output logic [CW-1:0] ce_cnt_o,
  output logic [CW-1:0] de_cnt_o,
  output logic [CW-1:0] gap_o,
  output logic          de_go_o
);

  localparam int NCNT = 2;

  logic [NCNT-1:0]     inc;
  logic [CW-1:0]       cnt_q [NCNT];

  assign inc = {de_inc_i, ce_inc_i};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q[g] <= '0;
      else if (clr_i)  cnt_q[g] <= '0;
      else if (inc[g]) cnt_q[g] <= cnt_q[g] + CW'(1);
    end
  end

  assign ce_cnt_o = cnt_q[0];
  assign de_cnt_o = cnt_q[1];
  // wraps modulo 2^CW
  assign gap_o    = cnt_q[1] - cnt_q[0];
  assign de_go_o  = cnt_q[0] > cnt_q[1];

endmodule

// File: rtl/ce_sync_seq.sv
module ce_sync_seq
  import ce_sync_pkg::*;
#(
  parameter int CRAM_AW = 8,
  parameter int CW      = 32,
  parameter int MAW     = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sub_start_i,
  input  logic           pkt_valid_i,
  input  logic [31:0]    pkt_data_i,
  output logic           pkt_ready_o,
  input  logic           de_inc_i,
  output logic           mem_wr_valid_o,
  input  logic           mem_wr_ready_i,
  output logic [MAW-1:0] mem_wr_addr_o,
  output logic [31:0]    mem_wr_data_o,
  output logic [CW-1:0]  ce_cnt_o,
  output logic [CW-1:0]  de_cnt_o,
  output logic           de_go_o,
  output logic           wait_o,
  output logic           err_o
);

  localparam int AW = CRAM_AW;
  localparam int LW = 15;  // holds count+1 for a 14-bit count

  seq_st_e       st_q;
  op_kind_e      kind_q;
  logic [LW-1:0] rem_q, idx_q;
  logic [AW-1:0] base_q;
  logic [31:0]   len_q, dump_k_q;
  logic [MAW-1:0] dst_q;
  logic [CW-1:0] diff_q;

  hdr_t          hdr;
  logic          acc, first_w, last_w, stall, ce_inc;
  logic [31:0]   len_nx;
  logic [CW-1:0] gap;
  logic          ram_we;
  logic [AW-1:0] ram_waddr, ram_raddr;
  logic [31:0]   ram_rdata;

  ce_sync_hdr_dec u_dec (
    .word_i (pkt_data_i[31:8]),
    .hdr_o  (hdr)
  );

  assign pkt_ready_o = (st_q == ST_HDR) || (st_q == ST_BODY);
  assign acc         = pkt_valid_i && pkt_ready_o;
  assign first_w     = (idx_q == '0);
  assign last_w      = (rem_q == LW'(1));
  assign stall       = (gap >= diff_q);
  assign len_nx      = (kind_q == OP_DUMP && idx_q == LW'(1)) ? pkt_data_i : len_q;

  assign ce_inc = acc && (st_q == ST_HDR) && hdr.type_ok && hdr.op_ok &&
                  (hdr.kind == OP_INC) && !sub_start_i;

  ce_sync_ctr #(.CW(CW)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (sub_start_i),
    .ce_inc_i (ce_inc),
    .de_inc_i (de_inc_i),
    .ce_cnt_o (ce_cnt_o),
    .de_cnt_o (de_cnt_o),
    .gap_o    (gap),
    .de_go_o  (de_go_o)
  );

  assign ram_we    = acc && (st_q == ST_BODY) && (kind_q == OP_WRC) && !first_w &&
                     !sub_start_i;
  assign ram_waddr = base_q + idx_q[AW-1:0] - AW'(1);
  assign ram_raddr = base_q + dump_k_q[AW-1:0];

  ce_sync_cram #(.AW(AW), .DW(32)) u_cram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (pkt_data_i),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_HDR;
      kind_q   <= OP_NONE;
      rem_q    <= '0;
      idx_q    <= '0;
      base_q   <= '0;
      len_q    <= '0;
      dst_q    <= '0;
      diff_q   <= '0;
      dump_k_q <= '0;
    end else if (sub_start_i) begin
      st_q <= ST_HDR;
    end else begin
      unique case (st_q)
        ST_HDR: if (acc) begin
          if (!hdr.type_ok || !hdr.op_ok) begin
            st_q <= ST_ERR;
          end else begin
            kind_q <= hdr.kind;
            rem_q  <= {1'b0, hdr.cnt} + LW'(1);
            idx_q  <= '0;
            len_q  <= '0;
            dst_q  <= '0;
            st_q   <= ST_BODY;
          end
        end
        ST_BODY: if (acc) begin
          rem_q <= rem_q - LW'(1);
          idx_q <= idx_q + LW'(1);
          unique case (kind_q)
            OP_WRC:  if (first_w) base_q <= pkt_data_i[AW-1:0];
            OP_DUMP: begin
              if (first_w)                 base_q <= pkt_data_i[AW-1:0];
              else if (idx_q == LW'(1))    len_q  <= pkt_data_i;
              else if (idx_q == LW'(2))    dst_q  <= pkt_data_i[MAW-1:0];
            end
            OP_WAIT: if (first_w) diff_q <= pkt_data_i[CW-1:0];
            default: ;
          endcase
          dump_k_q <= '0;
          if (kind_q == OP_WAIT && first_w)  st_q <= ST_WAIT;
          else if (last_w)
            st_q <= (kind_q == OP_DUMP && len_nx != '0) ? ST_DUMP : ST_HDR;
        end
        ST_WAIT: if (!stall) st_q <= (rem_q == '0) ? ST_HDR : ST_BODY;
        ST_DUMP: if (mem_wr_ready_i) begin
          dump_k_q <= dump_k_q + 32'd1;
          if (dump_k_q == len_q - 32'd1) st_q <= ST_HDR;
        end
        ST_ERR:  ;
        default: st_q <= ST_ERR;
      endcase
    end
  end

  assign mem_wr_valid_o = (st_q == ST_DUMP);
  assign mem_wr_addr_o  = dst_q + dump_k_q[MAW-1:0];
  assign mem_wr_data_o  = ram_rdata;
  assign wait_o         = (st_q == ST_WAIT);
  assign err_o          = (st_q == ST_ERR);

endmodule

// File: rtl/ce_sync_seq_chk.sv
module ce_sync_seq_chk #(
  parameter int CW  = 32,
  parameter int MAW = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           sub_start_i,
  input logic           pkt_ready_o,
  input logic           de_inc_i,
  input logic           mem_wr_valid_o,
  input logic           mem_wr_ready_i,
  input logic [MAW-1:0] mem_wr_addr_o,
  input logic [31:0]    mem_wr_data_o,
  input logic [CW-1:0]  ce_cnt_o,
  input logic [CW-1:0]  de_cnt_o,
  input logic           de_go_o,
  input logic           wait_o,
  input logic           err_o
);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_err_halts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !pkt_ready_o && !mem_wr_valid_o);

  assert_wait_halts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> !pkt_ready_o && !mem_wr_valid_o && !err_o);

  assert_ce_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !$past(sub_start_i) && ce_cnt_o != $past(ce_cnt_o))
      |-> ce_cnt_o == $past(ce_cnt_o) + CW'(1));

  assert_de_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && $past(de_inc_i) && !$past(sub_start_i))
      |-> de_cnt_o == $past(de_cnt_o) + CW'(1));

  assert_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_start_i |=> (ce_cnt_o == '0 && de_cnt_o == '0 && !err_o && !wait_o));

  assert_req_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_valid_o && !mem_wr_ready_i && !sub_start_i)
      |=> mem_wr_valid_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o));

  assert_go_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_go_o |-> ce_cnt_o != de_cnt_o);

endmodule

bind ce_sync_seq ce_sync_seq_chk #(.CW(CW), .MAW(MAW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sub_start_i    (sub_start_i),
  .pkt_ready_o    (pkt_ready_o),
  .de_inc_i       (de_inc_i),
  .mem_wr_valid_o (mem_wr_valid_o),
  .mem_wr_ready_i (mem_wr_ready_i),
  .mem_wr_addr_o  (mem_wr_addr_o),
  .mem_wr_data_o  (mem_wr_data_o),
  .ce_cnt_o       (ce_cnt_o),
  .de_cnt_o       (de_cnt_o),
  .de_go_o        (de_go_o),
  .wait_o         (wait_o),
  .err_o          (err_o)
);

// File: tb/ce_sync_seq_bench.sv
`timescale 1ns/1ps
module ce_sync_seq_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sub_start_i = 1'b0;
  logic        pkt_valid_i = 1'b0;
  logic [31:0] pkt_data_i = '0;
  logic        pkt_ready_o;
  logic        de_inc_i = 1'b0;
  logic        mem_wr_valid_o;
  logic        mem_wr_ready_i = 1'b0;
  logic [31:0] mem_wr_addr_o;
  logic [31:0] mem_wr_data_o;
  logic [31:0] ce_cnt_o, de_cnt_o;
  logic        de_go_o, wait_o, err_o;

  int tests = 0;
  int fails = 0;

  always #4 clk_i = ~clk_i;

  ce_sync_seq u_ce_sync_seq (.*);

  // header = {type[31:30], count[29:16], opcode[15:8], 8'h00}
  localparam int NPROG = 22;
  localparam logic [31:0] PROG [NPROG] = '{
    32'hC003_8100, 32'd10, 32'hA0A0_0001, 32'hA0A0_0002, 32'hA0A0_0003,
    32'hC001_1000, 32'h1234_5678, 32'h9ABC_DEF0,
    32'hC002_8100, 32'd255, 32'hB0B0_0001, 32'hB0B0_0002,
    32'hC002_8300, 32'd10, 32'd3, 32'h0000_1000,
    32'hC002_8300, 32'd255, 32'd2, 32'h0000_2000,
    32'hC000_8400, 32'd0
  };
  localparam int NEXP = 5;
  localparam logic [31:0] EXP_A [NEXP] = '{32'h1000, 32'h1001, 32'h1002, 32'h2000, 32'h2001};
  localparam logic [31:0] EXP_D [NEXP] = '{32'hA0A0_0001, 32'hA0A0_0002, 32'hA0A0_0003,
                                           32'hB0B0_0001, 32'hB0B0_0002};

  logic [31:0] cap_a [8];
  logic [31:0] cap_d [8];
  int ncap = 0;

  always @(negedge clk_i) mem_wr_ready_i <= ~mem_wr_ready_i;

  always @(posedge clk_i) begin
    if (rst_ni && mem_wr_valid_o && mem_wr_ready_i) begin
      if (ncap < 8) begin
        cap_a[ncap] = mem_wr_addr_o;
        cap_d[ncap] = mem_wr_data_o;
      end
      ncap++;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    pkt_valid_i = 1'b1;
    pkt_data_i  = w;
    #1;
    while (!pkt_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    pkt_valid_i = 1'b0;
  endtask

  task automatic pulse_de();
    de_inc_i = 1'b1;
    @(negedge clk_i);
    de_inc_i = 1'b0;
  endtask

  task automatic restart();
    sub_start_i = 1'b1;
    @(negedge clk_i);
    sub_start_i = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    // R1 reset state
    check("R1 ready", {31'd0, pkt_ready_o}, 32'd1);
    check("R1 ce", ce_cnt_o, 32'd0);
    check("R1 de", de_cnt_o, 32'd0);
    check("R1 err/wait/valid", {29'd0, err_o, wait_o, mem_wr_valid_o}, 32'd0);

    // table: R4 R5 R6 R7 R8
    for (int i = 0; i < NPROG; i++) send(PROG[i]);
    repeat (30) @(negedge clk_i);
    #1;
    check("R5 R7 request count", ncap, NEXP);
    for (int i = 0; i < NEXP; i++) begin
      check("R7 dump address", cap_a[i], EXP_A[i]);
      check("R6 R7 dump data", cap_d[i], EXP_D[i]);
    end
    check("R8 ce after inc", ce_cnt_o, 32'd1);
    check("R4 R5 no error after nop payload", {31'd0, err_o}, 32'd0);

    // R12 clear
    restart();
    check("R12 ce cleared", ce_cnt_o, 32'd0);
    check("R12 ready", {31'd0, pkt_ready_o}, 32'd1);

    // R9 R11
    repeat (3) pulse_de();
    #1;
    check("R9 de count", de_cnt_o, 32'd3);
    send(32'hC000_8400); send(32'd0);
    #1;
    check("R8 ce one", ce_cnt_o, 32'd1);
    check("R11 go low when behind", {31'd0, de_go_o}, 32'd0);

    // R10 gap 2 < 3 passes
    send(32'hC000_8800); send(32'd3);
    @(negedge clk_i); #1;
    check("R10 no stall below threshold", {30'd0, wait_o, pkt_ready_o}, 32'd1);
    // R10 gap 2 >= 2 stalls
    send(32'hC000_8800); send(32'd2);
    repeat (3) @(negedge clk_i);
    #1;
    check("R10 stall at threshold", {30'd0, wait_o, pkt_ready_o}, 32'd2);
    restart();
    check("R12 stall cleared", {30'd0, wait_o, pkt_ready_o}, 32'd1);

    // R10 wrap: ce=2, de=0, gap=FFFFFFFE
    send(32'hC000_8400); send(32'd0);
    send(32'hC000_8400); send(32'd0);
    #1;
    check("R11 go high when ahead", {31'd0, de_go_o}, 32'd1);
    send(32'hC000_8800); send(32'hFFFF_FFFE);
    #1;
    check("R10 wrapped stall", {31'd0, wait_o}, 32'd1);
    pulse_de();
    @(negedge clk_i); #1;
    check("R10 still stalled after one increment", {31'd0, wait_o}, 32'd1);
    pulse_de();
    @(negedge clk_i); #1;
    check("R10 released after wrap", {30'd0, wait_o, pkt_ready_o}, 32'd1);

    // R2 bad type
    send(32'h8000_8400);
    #1;
    check("R2 error halts", {30'd0, err_o, pkt_ready_o}, 32'd2);
    restart();
    check("R12 error cleared", {30'd0, err_o, pkt_ready_o}, 32'd1);

    // R3 unknown opcode
    send(32'hC000_5500);
    #1;
    check("R3 error halts", {30'd0, err_o, pkt_ready_o}, 32'd2);
    check("R3 ce unchanged", ce_cnt_o, 32'd0);
    restart();

    summary();
    $finish;
  end

endmodule